// File: doc/BRIEF.md
# Feistel Round Mixing Function

This block computes the keyed mixing function used inside each round of a 64-bit Feistel block cipher. It takes a 32-bit right half and a 48-bit round key. The half is widened to 48 bits by an overlapping expansion and the round key is XORed in. The result is cut into eight 6-bit groups, and each group addresses one of eight fixed 64-entry, 4-bit substitution ROMs. The eight 4-bit results are joined into a 32-bit word, and a fixed bit permutation of that word is the output. The left-half XOR, the half swap and the key schedule sit outside this block.

A parameter selects how the ROMs are built. They can be purely combinational, or they can have a registered output stage, as a synchronous block ROM would. In the registered build, `outValid` follows `inValid` one clock later. The ROM registers load only on a valid input and hold their contents otherwise. In the combinational build, `outValid` mirrors `inValid` in the same cycle.

Top module: `round_mix_f`

## Requirements
- R1: Bits are numbered 1..32 from the MSB of `rHalf`. Expansion group g (g = 0..7, group 0 most significant) takes input bits 4g, 4g+1, ..., 4g+5, where bit 0 means bit 32 and bit 33 means bit 1. Adjacent groups therefore share two bits, and the groups wrap at both ends. With `rHalf` all ones and a zero key, the output is 0x38DBF9CB.
- R2: The 48-bit expanded value is XORed with `roundKey` before substitution. A zero half with an all-ones key gives the same output as an all-ones half with a zero key, 0x38DBF9CB.
- R3: Let b1 be the MSB and b6 the LSB of a 6-bit group. The group addresses its ROM at {b1, b6, b2, b3, b4, b5}, so the outer bits select one of four rows and the middle four bits select one of sixteen columns. With R = 0xEF4A6544 and K = 0x79AED9DBC9E5, the output is 0x3CAB87A3.
- R4: Each of the eight ROMs holds the standard 64-entry, 4-bit table for its position. Group 0's result forms the most significant nibble of the 32-bit substitution word. With R = 0 and K = 0, the output is 0xD8D8DBBC.
- R5: Output bit i (1-indexed from the MSB) is substitution-word bit P[i], using the fixed 32-entry straight permutation table. With R = 0xCC017709 and K = 0x55FC8A42CF99, the output is 0x4D166EB0. With R = 0xA25C0BF4 and K = 0x72ADD6DB351D, the output is 0xBB23774C.
- R6: Known answer: with R = 0xF0AAF0AA and K = 0x1B02EFFC7072, the output is 0x234AA9BB.
- R7: With REG_ROM = 1, `outValid` is high in exactly the cycle after the cycle in which `inValid` was high. `fOut` holds the result for that input in the same cycle.
- R8: With REG_ROM = 0, `outValid` equals `inValid` in the same cycle, and `fOut` reflects the present inputs with no clock edge in between.
- R9: With REG_ROM = 1, a cycle with `inValid` low leaves `fOut` unchanged, even if `rHalf` and `roundKey` change.
- R10: With REG_ROM = 1, `outValid` and `fOut` are zero while `rstN` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input qualifier |
| rHalf | input | 32 | Right half of the round state |
| roundKey | input | 48 | Round key |
| outValid | output | 1 | Output qualifier |
| fOut | output | 32 | Mixed 32-bit result |

## Verification
The bench instantiates the block twice: once with REG_ROM = 1 and once with REG_ROM = 0. Both copies receive the same stimulus. One run therefore compares the same-cycle behaviour of the combinational ROMs against the one-cycle latency and hold behaviour of the registered ROMs. The vector set includes the all-zero and all-ones cases. Those cases put every ROM at its first or last address and exercise the wrap-around expansion bits. Four successive rounds of the standard known-answer example also run through both builds.

// File: rtl/rf_pkg.sv
package rf_pkg;

  localparam int HALF_W = 32;
  localparam int KEY_W  = 48;
  localparam int GRP_W  = 6;
  localparam int NIB_W  = 4;
  localparam int N_GRP  = 8;
  localparam int ROM_DEPTH = 1 << GRP_W;
  localparam int ROM_BITS  = ROM_DEPTH * NIB_W;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic outValid;
  } rf_strobe_t;

  // straight permutation: output position i (1-based, MSB first) takes this source bit
  localparam int unsigned PERM_TBL [HALF_W] = '{
    16,  7, 20, 21, 29, 12, 28, 17,
     1, 15, 23, 26,  5, 18, 31, 10,
     2,  8, 24, 14, 32, 27,  3,  9,
    19, 13, 30,  6, 22, 11,  4, 25
  };

  // Each table is written row by row; entry 0 is the leftmost nibble.
  function automatic logic [ROM_BITS-1:0] romImage(input int unsigned box);
    logic [ROM_BITS-1:0] img;
    case (box)
      0: img = {64'hE4D12FB83A6C5907, 64'h0F74E2D1A6CB9538,
                64'h41E8D62BFC973A50, 64'hFC8249175B3EA06D};
      1: img = {64'hF18E6B34972DC05A, 64'h3D47F28EC01A69B5,
                64'h0E7BA4D158C6932F, 64'hD8A13F42B67C05E9};
      2: img = {64'hA09E63F51DC7B428, 64'hD709346A285ECBF1,
                64'hD6498F30B12C5AE7, 64'h1AD069874FE3B52C};
      3: img = {64'h7DE3069A1285BC4F, 64'hD8B56F03472C1AE9,
                64'hA690CB7DF13E5284, 64'h3F06A1D8945BC72E};
      4: img = {64'h2C417AB6853FD0E9, 64'hEB2C47D150FA3986,
                64'h421BAD78F9C5630E, 64'hB8C71E2D6F09A453};
      5: img = {64'hC1AF92680D34E75B, 64'hAF427C9561DE0B38,
                64'h9EF528C3704A1DB6, 64'h432C95FABE17608D};
      6: img = {64'h4B2EF08D3C975A61, 64'hD0B7491AE35C2F86,
                64'h14BDC37EAF680592, 64'h6BD814A7950FE23C};
      default:
         img = {64'hD2846FB1A93E50C7, 64'h1FD8A374C56B0E92,
                64'h7B419CE206ADF358, 64'h21E74A8DFC90356B};
    endcase
    return img;
  endfunction

  function automatic logic [NIB_W-1:0] romRead(input int unsigned box,
                                               input logic [GRP_W-1:0] addr);
    logic [ROM_BITS-1:0] img;
    int unsigned top;
    img = romImage(box);
    top = ROM_BITS - 1 - NIB_W * int'(addr);
    return img[top -: NIB_W];
  endfunction

endpackage

// File: rtl/rf_sbox_rom.sv
module rf_sbox_rom #(
  parameter int BOX     = 0,
  parameter bit REG_ROM = 1'b1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     load,
  input  logic [rf_pkg::GRP_W-1:0] addr,
  output logic [rf_pkg::NIB_W-1:0] data
);
  import rf_pkg::*;

  logic [NIB_W-1:0] lookup;

  always_comb lookup = romRead(BOX, addr);

  generate
    if (REG_ROM) begin : g_reg
      logic [NIB_W-1:0] dataQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)     dataQ <= '0;
        else if (load) dataQ <= lookup;
      end
      assign data = dataQ;
    end else begin : g_comb
      assign data = lookup;
    end
  endgenerate

endmodule

// File: rtl/rf_ctrl.sv
module rf_ctrl #(
  parameter bit REG_ROM = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output rf_pkg::rf_strobe_t strobe
);
  import rf_pkg::*;

  generate
    if (REG_ROM) begin : g_reg
      logic validQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) validQ <= 1'b0;
        else       validQ <= inValid;
      end
      assign strobe.capture  = inValid;
      assign strobe.outValid = validQ;

      // R7: a valid output is always one cycle behind a valid input
      p_valid_lat_r7: assert property (@(posedge clk) disable iff (!rstN)
        strobe.outValid |-> $past(inValid));
      p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rstN)
        inValid |=> strobe.outValid);
      // R10: leaving reset, no valid is reported yet
      p_reset_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
        $rose(rstN) |-> !strobe.outValid);
    end else begin : g_comb
      assign strobe.capture  = inValid;
      assign strobe.outValid = inValid;
    end
  endgenerate

endmodule

// File: rtl/rf_datapath.sv
module rf_datapath #(
  parameter bit REG_ROM = 1'b1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  rf_pkg::rf_strobe_t        strobe,
  input  logic [rf_pkg::HALF_W-1:0] rHalf,
  input  logic [rf_pkg::KEY_W-1:0]  roundKey,
  output logic [rf_pkg::HALF_W-1:0] fOut
);
  import rf_pkg::*;

  localparam int STEP = HALF_W / N_GRP;

  logic [KEY_W-1:0]  expWord;
  logic [KEY_W-1:0]  mixWord;
  logic [HALF_W-1:0] subWord;

  // expansion: group g, slot b takes 1-based input bit ((STEP*g + b - 1) mod HALF_W) + 1
  for (genvar g = 0; g < N_GRP; g++) begin : g_exp
    for (genvar b = 0; b < GRP_W; b++) begin : g_bit
      localparam int SRC1 = ((STEP * g + b + HALF_W - 1) % HALF_W) + 1;
      assign expWord[KEY_W - 1 - GRP_W * g - b] = rHalf[HALF_W - SRC1];
    end
  end

  assign mixWord = expWord ^ roundKey;

  // substitution: row from outer bits, column from inner bits
  for (genvar g = 0; g < N_GRP; g++) begin : g_box
    logic [GRP_W-1:0] grp;
    logic [GRP_W-1:0] romAddr;
    logic [NIB_W-1:0] nib;

    assign grp     = mixWord[KEY_W - 1 - GRP_W * g -: GRP_W];
    assign romAddr = {grp[GRP_W-1], grp[0], grp[GRP_W-2:1]};

    rf_sbox_rom #(.BOX(g), .REG_ROM(REG_ROM)) u_rom (
      .clk  (clk),
      .rstN (rstN),
      .load (strobe.capture),
      .addr (romAddr),
      .data (nib)
    );

    assign subWord[HALF_W - 1 - NIB_W * g -: NIB_W] = nib;

    // R1: neighbouring groups overlap by two bits, wrapping at the ends
    p_overlap_r1: assert property (@(posedge clk) disable iff (!rstN)
      expWord[KEY_W - GRP_W * g - GRP_W + 1 -: 2] ==
      expWord[KEY_W - 1 - GRP_W * ((g + 1) % N_GRP) -: 2]);
  end

  // straight permutation
  for (genvar i = 1; i <= HALF_W; i++) begin : g_perm
    localparam int SRC = int'(PERM_TBL[i-1]);
    assign fOut[HALF_W - i] = subWord[HALF_W - SRC];
  end

  if (REG_ROM) begin : g_hold_chk
    // R9: the stored substitution word moves only on a captured input
    p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
      !$past(strobe.capture) |-> $stable(subWord));
    // R10: fresh out of reset the stored word is zero
    p_reset_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
      $rose(rstN) |-> (subWord == '0));
  end

endmodule

// File: rtl/round_mix_f.sv
module round_mix_f #(
  parameter bit REG_ROM = 1'b1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [31:0] rHalf,
  input  logic [47:0] roundKey,
  output logic        outValid,
  output logic [31:0] fOut
);
  import rf_pkg::*;

  rf_strobe_t strobe;

  rf_ctrl #(.REG_ROM(REG_ROM)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strobe  (strobe)
  );

  rf_datapath #(.REG_ROM(REG_ROM)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .rHalf    (rHalf),
    .roundKey (roundKey),
    .fOut     (fOut)
  );

  assign outValid = strobe.outValid;

endmodule

// File: tb/sim_round_mix_f.sv
module sim_round_mix_f;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] rHalf = '0;
  logic [47:0] roundKey = '0;
  logic        vReg, vComb;
  logic [31:0] fReg, fComb;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  round_mix_f #(.REG_ROM(1'b1)) u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .rHalf(rHalf),
    .roundKey(roundKey), .outValid(vReg), .fOut(fReg));

  round_mix_f #(.REG_ROM(1'b0)) u1 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .rHalf(rHalf),
    .roundKey(roundKey), .outValid(vComb), .fOut(fComb));

  localparam int NV = 7;
  localparam logic [31:0] V_R [NV] = '{
    32'h00000000, 32'hFFFFFFFF, 32'h00000000, 32'hF0AAF0AA,
    32'hEF4A6544, 32'hCC017709, 32'hA25C0BF4 };
  localparam logic [47:0] V_K [NV] = '{
    48'h000000000000, 48'h000000000000, 48'hFFFFFFFFFFFF, 48'h1B02EFFC7072,
    48'h79AED9DBC9E5, 48'h55FC8A42CF99, 48'h72ADD6DB351D };
  localparam logic [31:0] V_F [NV] = '{
    32'hD8D8DBBC, 32'h38DBF9CB, 32'h38DBF9CB, 32'h234AA9BB,
    32'h3CAB87A3, 32'h4D166EB0, 32'hBB23774C };
  // R4 zero case, R1 all-ones half, R2 key XOR, R6 known answer, R3 and R5 rounds
  localparam string V_TAG [NV] = '{"R4", "R1", "R2", "R6", "R3", "R5", "R5"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R10: reset state of the registered build
    chk("R10 outValid", {31'b0, vReg}, 32'h0);
    chk("R10 fOut", fReg, 32'h0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk("R10 after release", {31'b0, vReg}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      inValid  = 1'b1;
      rHalf    = V_R[i];
      roundKey = V_K[i];
      #1;
      chk({V_TAG[i], " R8 comb fOut"}, fComb, V_F[i]);
      chk("R8 comb outValid", {31'b0, vComb}, 32'h1);
      @(posedge clk);
      #1;
      chk({V_TAG[i], " R7 reg fOut"}, fReg, V_F[i]);
      chk("R7 reg outValid", {31'b0, vReg}, 32'h1);
    end

    // R9: idle cycle with changed inputs must not disturb the registered result
    @(negedge clk);
    inValid  = 1'b0;
    rHalf    = 32'h12345678;
    roundKey = 48'hA5A5A5A5A5A5;
    #1;
    chk("R8 comb outValid low", {31'b0, vComb}, 32'h0);
    @(posedge clk);
    #1;
    chk("R7 reg outValid drops", {31'b0, vReg}, 32'h0);
    chk("R9 reg fOut held", fReg, V_F[NV-1]);
    @(posedge clk);
    #1;
    chk("R9 reg fOut still held", fReg, V_F[NV-1]);

    // R7: single-cycle pulse, latency check
    @(negedge clk);
    inValid  = 1'b1;
    rHalf    = V_R[3];
    roundKey = V_K[3];
    #1;
    chk("R7 not yet valid", {31'b0, vReg}, 32'h0);
    @(negedge clk);
    inValid = 1'b0;
    #1;
    chk("R7 valid next cycle", {31'b0, vReg}, 32'h1);
    chk("R6 reg known answer", fReg, 32'h234AA9BB);
    @(posedge clk);
    #1;
    chk("R7 valid one cycle only", {31'b0, vReg}, 32'h0);

    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finishRun();
  end

endmodule